// File: doc/BRIEF.md
# Standby Rail and Shutdown Controller

This block controls the always-on standby power domain of a platform. It moves the domain between fully unpowered and soft-off. A power-up request turns on the standby rails. The block then waits for the core power-good input. After that it releases the resume reset and gives the chipset a bounded window to deassert its sleep-suspend signal. If the chipset does not respond in that window, the block drops the rails and falls back to unpowered.

A forced shutdown tears the domain down in a fixed order. The resume reset is pulled low first. One cycle later the rail enable is removed. The block then watches the deep-sleep power-ok and resume power-good inputs and waits a bounded time for either of them to collapse. If neither falls, a timeout flag is raised and the domain is still treated as off.

All six inputs pass through a synchronizer. Timeouts are counted in milliseconds, using a tick derived from the `CLK_HZ` parameter.

Top module: `stby_pwr_ctrl`

## Requirements
- R1: After reset, and in OFF, `rail_en_o`=0 and `rsm_rst_no`=0, and the block stays in OFF until a power-up request arrives. A power-up request in OFF moves the block to RAIL_UP with `rail_en_o`=1 and `rsm_rst_no`=0, and the block holds there while core power-good is low.
- R2: In RAIL_UP, a high core power-good moves the block to WAIT_SUS, sets `rsm_rst_no`=1 and starts the sleep-suspend timer.
- R3: In WAIT_SUS, `sus_n_i` high (sleep-suspend deasserted) moves the block to SOFT_OFF, with the rails on and the resume reset released.
- R4: In SOFT_OFF, `sus_n_i` low moves the block to OFF, with both outputs low.
- R5: If `sus_n_i` stays low for `SUS_MS` milliseconds in WAIT_SUS, the block moves to OFF and disables the rails.
- R6: A force-off request in RAIL_UP, WAIT_SUS or SOFT_OFF enters SHUTDOWN for exactly one cycle, with `rsm_rst_no`=0 and `rail_en_o`=1. The block then enters WAIT_DRAIN with `rail_en_o`=0, so the resume reset always falls before the rail enable.
- R7: In WAIT_DRAIN, `dsw_ok_i` low or `rsm_pg_i` low ends the wait on the following cycle, moving to OFF without a timeout. If both stay high for `DRAIN_MS` milliseconds, the block moves to OFF anyway.
- R8: `timeout_o` is set when either wait expires. It holds through OFF and clears when a power-up request is accepted.
- R9: A force-off request takes priority over a power-up request in the same cycle. In OFF, a force-off request is ignored.
- R10: `state_o` encodes the state as OFF=0, RAIL_UP=1, WAIT_SUS=2, SOFT_OFF=3, SHUTDOWN=4 and WAIT_DRAIN=5, and never shows 6 or 7. Inputs pass through `SYNC_STAGES` flops, and one millisecond is `CLK_HZ/1000` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwr_up_i | input | 1 | Power-up request |
| force_off_i | input | 1 | Forced shutdown request |
| core_pg_i | input | 1 | Core power-good |
| sus_n_i | input | 1 | Sleep-suspend, active low (high = deasserted) |
| dsw_ok_i | input | 1 | Deep-sleep power-ok |
| rsm_pg_i | input | 1 | Resume power-good |
| rail_en_o | output | 1 | Standby rail enable |
| rsm_rst_no | output | 1 | Resume reset, active low |
| state_o | output | 3 | State code |
| timeout_o | output | 1 | A wait expired since the last accepted power-up |

## Verification
The power-up path is exercised three ways: with a chipset that deasserts sleep-suspend promptly, with one that never does, and with one that reasserts it from soft-off. This separates the handshake-success, timeout and fall-back transitions. The drain wait is ended three ways: by deep-sleep power-ok falling, by resume power-good falling, and by neither falling. This shows that either input alone ends the wait early and that only the last case raises the flag. Simultaneous power-up and force-off requests, and a force-off seen cycle by cycle from soft-off, pin down the priority and the reset-before-rail ordering.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_RAIL_UP = 3'd1,
    ST_WAIT_SUS = 3'd2,
    ST_SOFT_OFF = 3'd3,
    ST_SHUTDOWN = 3'd4,
    ST_WAIT_DRAIN = 3'd5
  } state_e;
endpackage

// File: rtl/stby_sync.sv
module stby_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= '0;
        else         stg_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= '0;
        else         stg_q <= {stg_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/stby_tick.sv
module stby_tick #(
  parameter int DIV = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  assign tick_o = (pre_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (clr_i)   pre_q <= '0;
    else if (tick_o)  pre_q <= '0;
    else              pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/stby_ms_timer.sv
module stby_ms_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic [CW-1:0] limit_i,
  output logic          expired_o
);
  logic [CW-1:0] cnt_q;

  assign expired_o = (cnt_q == limit_i);

  // saturates at the limit so a stale wait cannot wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clr_i)                   cnt_q <= '0;
    else if (tick_i && !expired_o)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
  import stby_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   up_i,
  input  logic   off_i,
  input  logic   cpg_i,
  input  logic   susn_i,
  input  logic   dsw_i,
  input  logic   rpg_i,
  input  logic   expired_i,
  output state_e state_o,
  output logic   rail_en_o,
  output logic   rsm_rst_no,
  output logic   timeout_o,
  output logic   tmr_clr_o,
  output logic   sel_sus_o
);
  state_e state_q, nxt;
  logic   to_set, to_clr;
  logic   rail_q, rst_q, to_q;

  always_comb begin
    nxt    = state_q;
    to_set = 1'b0;
    to_clr = 1'b0;
    unique case (state_q)
      ST_OFF: begin
        if (up_i && !off_i) begin
          nxt    = ST_RAIL_UP;
          to_clr = 1'b1;
        end
      end
      ST_RAIL_UP: begin
        if (off_i)      nxt = ST_SHUTDOWN;
        else if (cpg_i) nxt = ST_WAIT_SUS;
      end
      ST_WAIT_SUS: begin
        if (off_i)          nxt = ST_SHUTDOWN;
        else if (susn_i)    nxt = ST_SOFT_OFF;
        else if (expired_i) begin
          nxt    = ST_OFF;
          to_set = 1'b1;
        end
      end
      ST_SOFT_OFF: begin
        if (off_i)        nxt = ST_SHUTDOWN;
        else if (!susn_i) nxt = ST_OFF;
      end
      ST_SHUTDOWN: nxt = ST_WAIT_DRAIN;
      ST_WAIT_DRAIN: begin
        if (!dsw_i || !rpg_i) nxt = ST_OFF;
        else if (expired_i) begin
          nxt    = ST_OFF;
          to_set = 1'b1;
        end
      end
      default: nxt = ST_OFF;
    endcase
  end

  assign tmr_clr_o = (nxt != state_q) && (nxt == ST_WAIT_SUS || nxt == ST_WAIT_DRAIN);
  assign sel_sus_o = (state_q == ST_WAIT_SUS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      rail_q  <= 1'b0;
      rst_q   <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      state_q <= nxt;
      rail_q  <= (nxt == ST_RAIL_UP) || (nxt == ST_WAIT_SUS) ||
                 (nxt == ST_SOFT_OFF) || (nxt == ST_SHUTDOWN);
      rst_q   <= (nxt == ST_WAIT_SUS) || (nxt == ST_SOFT_OFF);
      if (to_set)      to_q <= 1'b1;
      else if (to_clr) to_q <= 1'b0;
    end
  end

  assign state_o    = state_q;
  assign rail_en_o  = rail_q;
  assign rsm_rst_no = rst_q;
  assign timeout_o  = to_q;
endmodule

// File: rtl/stby_pwr_ctrl.sv
module stby_pwr_ctrl
  import stby_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int SUS_MS      = 250,
  parameter int DRAIN_MS    = 50,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr_up_i,
  input  logic       force_off_i,
  input  logic       core_pg_i,
  input  logic       sus_n_i,
  input  logic       dsw_ok_i,
  input  logic       rsm_pg_i,
  output logic       rail_en_o,
  output logic       rsm_rst_no,
  output logic [2:0] state_o,
  output logic       timeout_o
);
  localparam int TICK_DIV = CLK_HZ / 1000;
  localparam int MAX_MS   = (SUS_MS > DRAIN_MS) ? SUS_MS : DRAIN_MS;
  localparam int CW       = $clog2(MAX_MS + 1);
  localparam logic [CW-1:0] SUS_LIM   = CW'(SUS_MS);
  localparam logic [CW-1:0] DRAIN_LIM = CW'(DRAIN_MS);

  logic [5:0] raw, syn;
  logic up_s, off_s, cpg_s, susn_s, dsw_s, rpg_s;
  logic tick, expired, tmr_clr, sel_sus;
  state_e st;

  assign raw = {pwr_up_i, force_off_i, core_pg_i, sus_n_i, dsw_ok_i, rsm_pg_i};
  assign {up_s, off_s, cpg_s, susn_s, dsw_s, rpg_s} = syn;

  stby_sync #(.W(6), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(syn)
  );

  stby_tick #(.DIV(TICK_DIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(tmr_clr), .tick_o(tick)
  );

  stby_ms_timer #(.CW(CW)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(tmr_clr), .tick_i(tick),
    .limit_i(sel_sus ? SUS_LIM : DRAIN_LIM), .expired_o(expired)
  );

  stby_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .up_i(up_s), .off_i(off_s), .cpg_i(cpg_s), .susn_i(susn_s),
    .dsw_i(dsw_s), .rpg_i(rpg_s), .expired_i(expired),
    .state_o(st), .rail_en_o(rail_en_o), .rsm_rst_no(rsm_rst_no),
    .timeout_o(timeout_o), .tmr_clr_o(tmr_clr), .sel_sus_o(sel_sus)
  );

  assign state_o = st;
endmodule

// File: rtl/stby_pwr_ctrl_chk.sv
module stby_pwr_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       up_s,
  input logic       off_s,
  input logic       dsw_s,
  input logic       rpg_s,
  input logic       rail_en_o,
  input logic       rsm_rst_no,
  input logic [2:0] state_o,
  input logic       timeout_o
);
  // R10
  state_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o <= 3'd5);

  // R1
  off_outputs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd0) |-> (!rail_en_o && !rsm_rst_no));

  // R6
  shutdown_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd4) |-> (rail_en_o && !rsm_rst_no));

  // R6
  shutdown_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd4) |=> (state_o == 3'd5 && !rail_en_o));

  // R7
  drain_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd5 && (!dsw_s || !rpg_s)) |=> (state_o == 3'd0 && !timeout_o));

  // R8
  timeout_in_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> (state_o == 3'd0));

  // R9
  off_priority_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd0 && up_s && off_s) |=> (state_o == 3'd0));
endmodule

bind stby_pwr_ctrl stby_pwr_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .up_s(up_s), .off_s(off_s),
  .dsw_s(dsw_s), .rpg_s(rpg_s), .rail_en_o(rail_en_o),
  .rsm_rst_no(rsm_rst_no), .state_o(state_o), .timeout_o(timeout_o)
);

// File: tb/stby_pwr_ctrl_bench.sv
module stby_pwr_ctrl_bench;
  localparam int CLK_HZ = 8000; // 8 cycles per ms

  logic clk = 1'b0, rst_n = 1'b0;
  logic up = 0, off = 0, cpg = 0, susn = 0, dsw = 1, rpg = 1;
  logic rail, rstn_o, to;
  logic [2:0] st;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  stby_pwr_ctrl #(.CLK_HZ(CLK_HZ), .SUS_MS(250), .DRAIN_MS(50), .SYNC_STAGES(2)) u_stby_pwr_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .pwr_up_i(up), .force_off_i(off),
    .core_pg_i(cpg), .sus_n_i(susn), .dsw_ok_i(dsw), .rsm_pg_i(rpg),
    .rail_en_o(rail), .rsm_rst_no(rstn_o), .state_o(st), .timeout_o(to)
  );

  typedef struct packed {
    logic up, off, cpg, susn, dsw, rpg;
    logic [11:0] wt;
    logic [2:0] st;
    logic rail, rst, to;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t TBL [NV] = '{
    '{1,0,0,0,1,1,  6, 3'd1,1,0,0, 4'd1},
    '{0,0,0,0,1,1, 30, 3'd1,1,0,0, 4'd1},
    '{0,0,1,0,1,1,  6, 3'd2,1,1,0, 4'd2},
    '{0,0,1,1,1,1,  6, 3'd3,1,1,0, 4'd3},
    '{0,0,1,0,1,1,  6, 3'd0,0,0,0, 4'd4},
    '{1,0,1,0,1,1,  6, 3'd2,1,1,0, 4'd2},
    '{0,0,1,0,1,1,1900, 3'd2,1,1,0, 4'd5},
    '{0,0,1,0,1,1,200, 3'd0,0,0,1, 4'd5},
    '{1,0,0,0,1,1,  6, 3'd1,1,0,0, 4'd8},
    '{0,0,1,0,1,1,  6, 3'd2,1,1,0, 4'd2},
    '{0,0,1,1,1,1,  6, 3'd3,1,1,0, 4'd3},
    '{0,1,1,1,1,1,  6, 3'd5,0,0,0, 4'd6},
    '{0,0,1,1,1,1,300, 3'd5,0,0,0, 4'd7},
    '{0,0,1,1,1,1,150, 3'd0,0,0,1, 4'd8},
    '{1,1,0,0,1,1,  6, 3'd0,0,0,1, 4'd9},
    '{1,0,0,0,1,1,  6, 3'd1,1,0,0, 4'd8},
    '{0,1,0,0,1,1,  6, 3'd5,0,0,0, 4'd6},
    '{0,0,0,0,1,0,  6, 3'd0,0,0,0, 4'd7},
    '{1,0,0,0,1,1,  6, 3'd1,1,0,0, 4'd1},
    '{0,1,0,0,1,1,  6, 3'd5,0,0,0, 4'd6},
    '{0,0,0,0,0,1,  6, 3'd0,0,0,0, 4'd7},
    '{0,0,0,0,1,1,  6, 3'd0,0,0,0, 4'd1}
  };

  function automatic string req_name(input logic [3:0] r);
    case (r)
      4'd1: return "R1";  4'd2: return "R2";  4'd3: return "R3";
      4'd4: return "R4";  4'd5: return "R5";  4'd6: return "R6";
      4'd7: return "R7";  4'd8: return "R8";  4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [2:0] e_st,
                     input logic e_rail, input logic e_rst, input logic e_to);
    checks++;
    if (st !== e_st || rail !== e_rail || rstn_o !== e_rst || to !== e_to) begin
      fails++;
      $display("FAIL %s: actual st=%0d rail=%b rst=%b to=%b expected st=%0d rail=%b rst=%b to=%b",
               tag, st, rail, rstn_o, to, e_st, e_rail, e_rst, e_to);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R10: watchdog expired, actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int first_rst, first_rail;
    bit saw_sd;
    cyc(3);
    chk("R1 reset", 3'd0, 0, 0, 0);
    rst_n = 1'b1;
    cyc(1);

    for (int i = 0; i < NV; i++) begin
      {up, off, cpg, susn, dsw, rpg} = {TBL[i].up, TBL[i].off, TBL[i].cpg,
                                         TBL[i].susn, TBL[i].dsw, TBL[i].rpg};
      cyc(int'(TBL[i].wt));
      chk(req_name(TBL[i].req), TBL[i].st, TBL[i].rail, TBL[i].rst, TBL[i].to);
    end

    // R6: cycle-by-cycle order from SOFT_OFF
    up = 1; cyc(6); up = 0; cpg = 1; cyc(6); susn = 1; cyc(6);
    chk("R3 soft-off before shutdown", 3'd3, 1, 1, 0);
    off = 1;
    first_rst = -1; first_rail = -1; saw_sd = 0;
    for (int c = 1; c <= 8; c++) begin
      cyc(1);
      if (first_rst < 0 && !rstn_o) first_rst = c;
      if (first_rail < 0 && !rail) first_rail = c;
      if (st == 3'd4) saw_sd = 1;
    end
    checks++;
    if (!(first_rst > 0 && first_rail == first_rst + 1 && saw_sd)) begin
      fails++;
      $display("FAIL R6: actual rst_low@%0d rail_low@%0d shutdown_seen=%b expected rail one cycle after rst, shutdown_seen=1",
               first_rst, first_rail, saw_sd);
    end
    off = 0; rpg = 0; cyc(6);
    chk("R7 drain via resume pg", 3'd0, 0, 0, 0);

    // R1: async reset from a powered state
    rpg = 1; cpg = 1; susn = 1; up = 1; cyc(6); up = 0; cyc(6);
    chk("R3 soft-off again", 3'd3, 1, 1, 0);
    #3 rst_n = 0; #2;
    chk("R1 async reset", 3'd0, 0, 0, 0);
    cyc(2); rst_n = 1; cyc(6);
    chk("R1 stays off after reset", 3'd0, 0, 0, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule